// File: doc/BRIEF.md
# Four-Channel DMA Priority Arbiter

This block decides, once per clock, which of four DMA channels gets the bus. Each channel raises a request line. A two-bit mode input selects the rule for the decision. Three of its codes give fixed channel rankings. The fourth gives a rotating scheme in which the channel that last won drops to the bottom of the ranking. The decision is registered, so the one-hot grant and its valid flag appear one clock after the inputs they were computed from.

A global enable must be high for any grant to be issued. Two sticky fault flags stop all arbitration while either of them is set:
- an address-error flag, and
- a non-maskable-interrupt flag.

Each flag is raised by a one-cycle pulse and stays raised until its own clear strobe arrives. The channels themselves, and any data movement, sit outside this block.

Top module: `dma_chan_arbiter`

## Requirements
- R1: After reset, `grant` is 0000 and `grant_vld` is 0. At all times `grant` has at most one bit set, and `grant_vld` is 1 exactly when `grant` is non-zero. Bit k of `grant` stands for channel k.
- R2: The grant is registered. The outputs after a rising edge reflect `req`, `mode`, `master_en` and the fault inputs sampled at that edge. Only a channel whose `req` bit was 1 is granted. When the block is enabled, no fault blocks it and some request is present, a grant is always made.
- R3: With `mode` = 00 the ranking, highest first, is channel 0, 1, 2, 3.
- R4: With `mode` = 01 the ranking, highest first, is channel 0, 2, 3, 1.
- R5: With `mode` = 10 the ranking, highest first, is channel 2, 0, 1, 3.
- R6: With `mode` = 11 the search starts at the channel one above the channel last granted in this mode, wraps from 3 to 0, and takes the first requester found. After reset the search starts at channel 0. Grants made in the other modes leave the starting point unchanged.
- R7: When `master_en` is 0 at an edge, no grant is issued for that edge.
- R8: A pulse on `addr_err_set` sets the address-error flag. No grant is issued for that edge or any later edge until an `addr_err_clr` strobe has been seen. The decision at the edge that takes the clear is still blocked; grants resume at the following edge. When set and clear arrive together, the flag is set.
- R9: The NMI flag behaves as in R8, driven by `nmi_set` and `nmi_clr`, and independently of the address-error flag.
- R10: A change of `mode` applies to the decision taken at the very next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 4 | Channel request lines, bit k = channel k |
| mode | input | 2 | Arbitration rule: 00, 01, 10 fixed orders, 11 rotating |
| master_en | input | 1 | Global enable for all grants |
| addr_err_set | input | 1 | Pulse that raises the address-error flag |
| addr_err_clr | input | 1 | Strobe that lowers the address-error flag |
| nmi_set | input | 1 | Pulse that raises the NMI flag |
| nmi_clr | input | 1 | Strobe that lowers the NMI flag |
| grant | output | 4 | Registered one-hot grant |
| grant_vld | output | 1 | High when a grant is present |

## Verification
The bench builds the block with its default of four channels, which is the only count the three fixed rankings are defined for. At that size every request pattern of the four lines can be reached. This includes every wrap position of the rotating search, and mode switches between the rotating rule and the fixed rules while the rotation pointer is at each of its four values. Random fault pulses, clear strobes and enable drops are mixed in, so that blocking and release are exercised in every mode.

// File: rtl/dmarb_pkg.sv
package dmarb_pkg;
   typedef enum logic [1:0] {
      ARB_ORD_A  = 2'b00,
      ARB_ORD_B  = 2'b01,
      ARB_ORD_C  = 2'b10,
      ARB_ROTATE = 2'b11
   } arb_mode_e;

   localparam int FAULT_CNT = 2;
endpackage

// File: rtl/dmarb_fault_flag.sv
module dmarb_fault_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o,
   output logic block_o
);
   // set has priority over clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag_o <= 1'b0;
      else if (set_i)  flag_o <= 1'b1;
      else if (clr_i)  flag_o <= 1'b0;
   end

   // a pulse blocks the decision taken at the same edge
   assign block_o = flag_o | set_i;

   // R8 / R9: flag stays up until a clear strobe
   a_r8_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o && !clr_i) |=> flag_o);
   a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> flag_o);
endmodule

// File: rtl/dmarb_fixed_pick.sv
module dmarb_fixed_pick #(
   parameter int NUM_CH = 4
) (
   input  logic [NUM_CH-1:0] req_i,
   input  logic [1:0]        mode_i,
   output logic [NUM_CH-1:0] gnt_o
);
   localparam int IW = $clog2(NUM_CH);
   // rank r stored at bits [IW*r +: IW], rank 0 highest
   localparam logic [NUM_CH*IW-1:0] RANK_A = {2'd3, 2'd2, 2'd1, 2'd0};
   localparam logic [NUM_CH*IW-1:0] RANK_B = {2'd1, 2'd3, 2'd2, 2'd0};
   localparam logic [NUM_CH*IW-1:0] RANK_C = {2'd3, 2'd1, 2'd0, 2'd2};

   generate
      if (NUM_CH != 4) begin : g_bad_count
         $error("dmarb_fixed_pick: fixed rankings need NUM_CH == 4");
      end
   endgenerate

   logic [NUM_CH*IW-1:0] table_sel;
   always_comb begin
      case (mode_i)
         2'b01:   table_sel = RANK_B;
         2'b10:   table_sel = RANK_C;
         default: table_sel = RANK_A;
      endcase
   end

   always_comb begin
      gnt_o = '0;
      for (int r = NUM_CH - 1; r >= 0; r--) begin
         logic [IW-1:0] ch;
         ch = table_sel[IW*r +: IW];
         if (req_i[ch]) begin
            gnt_o     = '0;
            gnt_o[ch] = 1'b1;
         end
      end
   end
endmodule

// File: rtl/dmarb_rr_pick.sv
module dmarb_rr_pick #(
   parameter int NUM_CH = 4
) (
   input  logic [NUM_CH-1:0]         req_i,
   input  logic [$clog2(NUM_CH)-1:0] start_i,
   output logic [NUM_CH-1:0]         gnt_o,
   output logic [$clog2(NUM_CH)-1:0] idx_o
);
   localparam int IW = $clog2(NUM_CH);

   generate
      if (NUM_CH < 2) begin : g_bad_count
         $error("dmarb_rr_pick: need at least two channels");
      end
   endgenerate

   always_comb begin
      gnt_o = '0;
      idx_o = '0;
      for (int k = NUM_CH - 1; k >= 0; k--) begin
         logic [IW-1:0] cand;
         cand = IW'((int'(start_i) + k) % NUM_CH);
         if (req_i[cand]) begin
            gnt_o       = '0;
            gnt_o[cand] = 1'b1;
            idx_o       = cand;
         end
      end
   end
endmodule

// File: rtl/dma_chan_arbiter.sv
module dma_chan_arbiter #(
   parameter int NUM_CH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] req,
   input  logic [1:0]        mode,
   input  logic              master_en,
   input  logic              addr_err_set,
   input  logic              addr_err_clr,
   input  logic              nmi_set,
   input  logic              nmi_clr,
   output logic [NUM_CH-1:0] grant,
   output logic              grant_vld
);
   import dmarb_pkg::*;
   localparam int IW = $clog2(NUM_CH);

   // ---- fault flags (R8, R9) ----
   logic [FAULT_CNT-1:0] f_set, f_clr, f_flag, f_block;
   assign f_set = {nmi_set, addr_err_set};
   assign f_clr = {nmi_clr, addr_err_clr};

   generate
      for (genvar i = 0; i < FAULT_CNT; i++) begin : g_fault
         dmarb_fault_flag u_flag (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_i   (f_set[i]),
            .clr_i   (f_clr[i]),
            .flag_o  (f_flag[i]),
            .block_o (f_block[i])
         );
      end
   endgenerate

   // ---- candidate selection ----
   arb_mode_e        mode_e;
   logic [NUM_CH-1:0] fix_gnt, rr_gnt, pick;
   logic [IW-1:0]     rr_idx, rr_start;
   logic              issue, rotate;

   assign mode_e = arb_mode_e'(mode);
   assign rotate = (mode_e == ARB_ROTATE);

   dmarb_fixed_pick #(.NUM_CH(NUM_CH)) u_fixed (
      .req_i  (req),
      .mode_i (mode),
      .gnt_o  (fix_gnt)
   );

   dmarb_rr_pick #(.NUM_CH(NUM_CH)) u_rr (
      .req_i   (req),
      .start_i (rr_start),
      .gnt_o   (rr_gnt),
      .idx_o   (rr_idx)
   );

   assign pick  = rotate ? rr_gnt : fix_gnt;
   assign issue = master_en && !(|f_block) && (|req);

   // ---- registered decision (R1, R2, R10) ----
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         grant     <= '0;
         grant_vld <= 1'b0;
      end else begin
         grant     <= issue ? pick : '0;
         grant_vld <= issue;
      end
   end

   // ---- rotation pointer (R6) ----
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rr_start <= '0;
      end else if (issue && rotate) begin
         rr_start <= (int'(rr_idx) == NUM_CH - 1) ? '0 : rr_idx + 1'b1;
      end
   end

   // ---- assertions ----
   a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));
   a_r1_valid_match: assert property (@(posedge clk) disable iff (!rst_n)
      grant_vld == (grant != '0));
   a_r2_only_requesters: assert property (@(posedge clk) disable iff (!rst_n)
      (|req) |=> ((grant & ~$past(req)) == '0));
   a_r2_no_req_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
      (req == '0) |=> !grant_vld);
   a_r2_work_conserving: assert property (@(posedge clk) disable iff (!rst_n)
      (master_en && (|req) && f_flag == '0 && f_set == '0) |=> grant_vld);
   a_r7_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      !master_en |=> !grant_vld);
   a_r8_err_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (f_flag[0] || addr_err_set) |=> !grant_vld);
   a_r9_nmi_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (f_flag[1] || nmi_set) |=> !grant_vld);
endmodule

// File: tb/dma_chan_arbiter_bench.sv
module dma_chan_arbiter_bench;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] req = '0;
   logic [1:0] mode = '0;
   logic       master_en = 1'b0;
   logic       addr_err_set = 1'b0, addr_err_clr = 1'b0;
   logic       nmi_set = 1'b0, nmi_clr = 1'b0;
   logic [3:0] grant;
   logic       grant_vld;

   int compared = 0;
   int mismatched = 0;
   bit finished = 0;

   // bench model state
   bit       m_err = 0, m_nmi = 0;
   int       m_start = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dma_chan_arbiter u_dma_chan_arbiter (
      .clk(clk), .rst_n(rst_n), .req(req), .mode(mode), .master_en(master_en),
      .addr_err_set(addr_err_set), .addr_err_clr(addr_err_clr),
      .nmi_set(nmi_set), .nmi_clr(nmi_clr),
      .grant(grant), .grant_vld(grant_vld)
   );

   // ranking per mode, index 0 highest (R3, R4, R5)
   function automatic int rank_of(input int m, input int r);
      int ra[4] = '{0, 1, 2, 3};
      int rb[4] = '{0, 2, 3, 1};
      int rc[4] = '{2, 0, 1, 3};
      case (m)
         1: return rb[r];
         2: return rc[r];
         default: return ra[r];
      endcase
   endfunction

   function automatic int fixed_ch(input int m, input logic [3:0] r);
      for (int i = 0; i < 4; i++)
         if (r[rank_of(m, i)]) return rank_of(m, i);
      return -1;
   endfunction

   function automatic int rot_ch(input int st, input logic [3:0] r);
      for (int i = 0; i < 4; i++)
         if (r[(st + i) % 4]) return (st + i) % 4;
      return -1;
   endfunction

   task automatic check(input string tag, input logic [3:0] exp_g, input logic exp_v);
      compared++;
      if (grant !== exp_g || grant_vld !== exp_v || $countones(grant) > 1) begin
         mismatched++;
         $display("FAIL %s: grant=%b vld=%b expected grant=%b vld=%b",
                  tag, grant, grant_vld, exp_g, exp_v);
      end
   endtask

   // drive at negedge, predict, clock once, compare at next negedge
   task automatic step(input logic [3:0] r, input logic [1:0] m, input logic en,
                       input logic es, input logic ec, input logic ns, input logic nc,
                       input string tag_in);
      logic [3:0] eg;
      logic       ev;
      int         ch;
      string      tag;
      bit         blk_e, blk_n;
      req = r; mode = m; master_en = en;
      addr_err_set = es; addr_err_clr = ec; nmi_set = ns; nmi_clr = nc;
      blk_e = m_err | es;
      blk_n = m_nmi | ns;
      eg = '0; ev = 1'b0;
      if (en && !blk_e && !blk_n && r != 0) begin
         if (m == 2'b11) begin
            ch = rot_ch(m_start, r);
            m_start = (ch + 1) % 4;
         end else begin
            ch = fixed_ch(int'(m), r);
         end
         eg[ch] = 1'b1; ev = 1'b1;
      end
      if (es) m_err = 1; else if (ec) m_err = 0;
      if (ns) m_nmi = 1; else if (nc) m_nmi = 0;
      if (tag_in != "") tag = tag_in;
      else if (blk_e) tag = "R8";
      else if (blk_n) tag = "R9";
      else if (!en) tag = "R7";
      else if (r == 0) tag = "R2";
      else case (m)
         2'b00: tag = "R3";
         2'b01: tag = "R4";
         2'b10: tag = "R5";
         default: tag = "R6";
      endcase
      @(posedge clk);
      @(negedge clk);
      check(tag, eg, ev);
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!finished) begin
         compared++;
         mismatched++;
         $display("FAIL watchdog: run hung, actual=timeout expected=done");
         summary();
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      check("R1 reset", 4'b0000, 1'b0);
      rst_n = 1'b1;

      // R3 fixed order 0,1,2,3
      step(4'b1111, 2'b00, 1, 0,0,0,0, "R3 all");
      step(4'b1110, 2'b00, 1, 0,0,0,0, "R3 no0");
      step(4'b1000, 2'b00, 1, 0,0,0,0, "R3 only3");
      // R4 fixed order 0,2,3,1
      step(4'b1111, 2'b01, 1, 0,0,0,0, "R4 all");
      step(4'b1010, 2'b01, 1, 0,0,0,0, "R4 3over1");
      step(4'b1110, 2'b01, 1, 0,0,0,0, "R4 2first");
      // R5 fixed order 2,0,1,3; R10 mode switch applies next edge
      step(4'b1111, 2'b10, 1, 0,0,0,0, "R5 R10 all");
      step(4'b1011, 2'b10, 1, 0,0,0,0, "R5 0over1");
      step(4'b1010, 2'b10, 1, 0,0,0,0, "R5 1over3");
      // R6 rotation from reset start 0, fixed grants above did not move it
      step(4'b1111, 2'b11, 1, 0,0,0,0, "R6 start0");
      step(4'b1111, 2'b11, 1, 0,0,0,0, "R6 next1");
      step(4'b1111, 2'b11, 1, 0,0,0,0, "R6 next2");
      step(4'b1111, 2'b11, 1, 0,0,0,0, "R6 next3");
      step(4'b1111, 2'b11, 1, 0,0,0,0, "R6 wrap");
      step(4'b0001, 2'b11, 1, 0,0,0,0, "R6 sole");
      step(4'b0001, 2'b00, 1, 0,0,0,0, "R6 R10 fixed keeps ptr");
      step(4'b1001, 2'b11, 1, 0,0,0,0, "R6 after fixed");
      // R2 no request
      step(4'b0000, 2'b00, 1, 0,0,0,0, "R2 idle");
      // R7 disable
      step(4'b1111, 2'b00, 0, 0,0,0,0, "R7 disabled");
      // R8 address error
      step(4'b1111, 2'b00, 1, 1,0,0,0, "R8 set edge");
      step(4'b1111, 2'b00, 1, 0,0,0,0, "R8 held");
      step(4'b1111, 2'b00, 1, 1,1,0,0, "R8 set beats clr");
      step(4'b1111, 2'b00, 1, 0,1,0,0, "R8 clr edge");
      step(4'b1111, 2'b00, 1, 0,0,0,0, "R8 resumed");
      // R9 NMI
      step(4'b0110, 2'b10, 1, 0,0,1,0, "R9 set edge");
      step(4'b0110, 2'b10, 1, 0,0,0,0, "R9 held");
      step(4'b0110, 2'b10, 1, 0,0,0,1, "R9 clr edge");
      step(4'b0110, 2'b10, 1, 0,0,0,0, "R9 resumed");

      // constrained random mix
      for (int n = 0; n < 4000; n++) begin
         logic [3:0] r;
         logic [1:0] m;
         r = 4'($urandom_range(0, 15));
         m = 2'($urandom_range(0, 3));
         step(r, m, ($urandom_range(0, 9) != 0),
              ($urandom_range(0, 39) == 0), ($urandom_range(0, 5) == 0),
              ($urandom_range(0, 39) == 0), ($urandom_range(0, 5) == 0), "");
      end

      finished = 1;
      summary();
      $finish;
   end
endmodule